// File: doc/BRIEF.md
# Four-Word-Burst QDR II Command Scheduler

This block sits between two request queues (one for writes, one for reads) and a four-word-burst QDR II SRAM whose read and write commands share a single SDR address bus. It looks at each queue's empty flag, pops the head entry with an active-low strobe, and turns that entry into a one-cycle active-low memory command with the matching address. Nothing is issued until calibration has finished.

Reads and writes never share a cycle. When both queues hold work, the two kinds alternate on every cycle. When only one queue holds work, each command is followed by an idle cycle. From idle, a waiting write goes first. A write burst is four data words. The first pair appears on the low and high data outputs in the command cycle, and the second pair follows in the next cycle. Each word carries its own active-low byte enables. The queues are show-ahead: the head entry is valid while its empty flag is low. The pop strobe takes the head at the next rising edge.

Top module: `qdr_burst_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it: both memory controls and both pop strobes are high, the address is zero, both data outputs are zero and all byte enables are high (inactive).
- R2: No pop and no memory command occur until cal_done has been sampled high. If both queues are already non-empty when cal_done is first sampled high at edge E, the first write command appears on the outputs two edges after E.
- R3: When the scheduler is idle and both queues are non-empty, the write is popped first. The read follows in the next cycle.
- R4: Each write pop (wq_pop_n low) lasts exactly one cycle. In the following cycle mem_w_n is low for one cycle, and mem_addr holds the popped write address.
- R5: Each read pop (rq_pop_n low) lasts exactly one cycle. In the following cycle mem_r_n is low for one cycle, and mem_addr holds the popped read address.
- R6: While both queues stay non-empty, write and read commands alternate in consecutive cycles, with no idle cycle between them.
- R7: Two commands of the same kind are never in adjacent cycles. With only writes queued, or only reads queued, a command is issued every second cycle.
- R8: mem_w_n and mem_r_n are never low in the same cycle.
- R9: In the write command cycle, mem_d_lo and mem_d_hi carry words 0 and 1. In the next cycle they carry words 2 and 3. In every other cycle both are zero.
- R10: mem_be_lo_n and mem_be_hi_n carry the byte enables of the word on mem_d_lo and mem_d_hi in the same cycle. There is one active-low bit per 9-bit lane. All enable bits are high outside a burst.
- R11: In a cycle with no command, mem_addr keeps the address of the last command.
- R12: While both queues are empty after calibration, no pop and no command occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_done | input | 1 | Calibration finished, releases traffic |
| wq_empty | input | 1 | Write queue has no entry |
| wq_pop_n | output | 1 | Active-low pop of the write queue head |
| wq_addr | input | AW | Head write address |
| wq_word0 | input | DW | Head burst word 0 |
| wq_word1 | input | DW | Head burst word 1 |
| wq_word2 | input | DW | Head burst word 2 |
| wq_word3 | input | DW | Head burst word 3 |
| wq_be0_n | input | DW/9 | Byte enables of word 0, active low |
| wq_be1_n | input | DW/9 | Byte enables of word 1, active low |
| wq_be2_n | input | DW/9 | Byte enables of word 2, active low |
| wq_be3_n | input | DW/9 | Byte enables of word 3, active low |
| rq_empty | input | 1 | Read queue has no entry |
| rq_pop_n | output | 1 | Active-low pop of the read queue head |
| rq_addr | input | AW | Head read address |
| mem_w_n | output | 1 | Memory write control, active low |
| mem_r_n | output | 1 | Memory read control, active low |
| mem_addr | output | AW | Shared SDR memory address |
| mem_d_lo | output | DW | Write data, first word of each pair |
| mem_d_hi | output | DW | Write data, second word of each pair |
| mem_be_lo_n | output | DW/9 | Byte enables for mem_d_lo |
| mem_be_hi_n | output | DW/9 | Byte enables for mem_d_hi |

## Verification
Two kinds of work can land in one cycle. The second data beat of a write burst can coincide with a read command, and a read pop can coincide with the register stage that launches a write command. To provoke both, the queues are preloaded with several writes and reads before calibration completes, so the alternating stream starts at full rate. Each read command cycle is then checked for the correct read address together with words 2 and 3 of the previous write. The controls are also checked to stay mutually exclusive throughout.

// File: rtl/qdr_sched_pkg.sv
package qdr_sched_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } sched_state_t;

  // Number of 9-bit byte lanes in a data word.
  function automatic int lane_count(input int word_bits);
    return (word_bits + 8) / 9;
  endfunction

  // Next-state rule: writes win from idle, opposite kinds alternate,
  // and a command of one kind is never followed directly by the same kind.
  function automatic sched_state_t next_state(input sched_state_t cur,
                                              input logic cal,
                                              input logic w_empty,
                                              input logic r_empty);
    sched_state_t nxt;
    nxt = cur;
    case (cur)
      ST_INIT:  nxt = cal ? ST_IDLE : ST_INIT;
      ST_IDLE:  nxt = !w_empty ? ST_WRITE : (!r_empty ? ST_READ : ST_IDLE);
      ST_WRITE: nxt = !r_empty ? ST_READ  : ST_IDLE;
      ST_READ:  nxt = !w_empty ? ST_WRITE : ST_IDLE;
      default:  nxt = ST_INIT;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/qdr_sched_fsm.sv
module qdr_sched_fsm
  import qdr_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cal_done,
  input  logic wq_empty,
  input  logic rq_empty,
  output logic wq_pop_n,
  output logic rq_pop_n,
  output logic wr_issue,
  output logic rd_issue
);

  sched_state_t state_q;
  sched_state_t state_d;

  always_comb state_d = next_state(state_q, cal_done, wq_empty, rq_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  assign wr_issue = (state_q == ST_WRITE);
  assign rd_issue = (state_q == ST_READ);
  assign wq_pop_n = !wr_issue;
  assign rq_pop_n = !rd_issue;

  // R3: a waiting write is taken first when leaving idle
  assert_write_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wq_empty) |=> !wq_pop_n);

  // R12: idle with empty queues produces no pop
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wq_empty && rq_empty) |=> (wq_pop_n && rq_pop_n));

  // R4: a write pop lasts one cycle
  assert_wpop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wq_pop_n |=> wq_pop_n);

  // R5: a read pop lasts one cycle
  assert_rpop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_pop_n |=> rq_pop_n);

endmodule

// File: rtl/qdr_cmd_out.sv
module qdr_cmd_out #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_issue,
  input  logic          rd_issue,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          mem_w_n,
  output logic          mem_r_n,
  output logic [AW-1:0] mem_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_w_n  <= 1'b1;
      mem_r_n  <= 1'b1;
      mem_addr <= '0;
    end else begin
      mem_w_n <= !wr_issue;
      mem_r_n <= !rd_issue;
      if (wr_issue)      mem_addr <= wr_addr;
      else if (rd_issue) mem_addr <= rd_addr;
    end
  end

  // R8: shared address bus, never both controls
  assert_ctrl_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_w_n && !mem_r_n));

  // R7: no back-to-back writes
  assert_w_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n |=> mem_w_n);

  // R7: no back-to-back reads
  assert_r_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_r_n |=> mem_r_n);

endmodule

// File: rtl/qdr_wburst_seq.sv
module qdr_wburst_seq #(
  parameter int DW = 36,
  parameter int BL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] w2,
  input  logic [DW-1:0] w3,
  input  logic [BL-1:0] b0_n,
  input  logic [BL-1:0] b1_n,
  input  logic [BL-1:0] b2_n,
  input  logic [BL-1:0] b3_n,
  output logic [DW-1:0] d_lo,
  output logic [DW-1:0] d_hi,
  output logic [BL-1:0] be_lo_n,
  output logic [BL-1:0] be_hi_n
);

  logic          second_pending;
  logic [DW-1:0] hold_lo, hold_hi;
  logic [BL-1:0] hold_be_lo_n, hold_be_hi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_pending <= 1'b0;
      hold_lo        <= '0;
      hold_hi        <= '0;
      hold_be_lo_n   <= '1;
      hold_be_hi_n   <= '1;
      d_lo           <= '0;
      d_hi           <= '0;
      be_lo_n        <= '1;
      be_hi_n        <= '1;
    end else if (load) begin
      second_pending <= 1'b1;
      hold_lo        <= w2;
      hold_hi        <= w3;
      hold_be_lo_n   <= b2_n;
      hold_be_hi_n   <= b3_n;
      d_lo           <= w0;
      d_hi           <= w1;
      be_lo_n        <= b0_n;
      be_hi_n        <= b1_n;
    end else if (second_pending) begin
      second_pending <= 1'b0;
      d_lo           <= hold_lo;
      d_hi           <= hold_hi;
      be_lo_n        <= hold_be_lo_n;
      be_hi_n        <= hold_be_hi_n;
    end else begin
      d_lo    <= '0;
      d_hi    <= '0;
      be_lo_n <= '1;
      be_hi_n <= '1;
    end
  end

  // R9: the second beat always follows the first and is never pre-empted
  assert_second_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> second_pending);

endmodule

// File: rtl/qdr_burst_sched.sv
module qdr_burst_sched
  import qdr_sched_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 36,
  localparam int BL = lane_count(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_done,
  input  logic          wq_empty,
  output logic          wq_pop_n,
  input  logic [AW-1:0] wq_addr,
  input  logic [DW-1:0] wq_word0,
  input  logic [DW-1:0] wq_word1,
  input  logic [DW-1:0] wq_word2,
  input  logic [DW-1:0] wq_word3,
  input  logic [BL-1:0] wq_be0_n,
  input  logic [BL-1:0] wq_be1_n,
  input  logic [BL-1:0] wq_be2_n,
  input  logic [BL-1:0] wq_be3_n,
  input  logic          rq_empty,
  output logic          rq_pop_n,
  input  logic [AW-1:0] rq_addr,
  output logic          mem_w_n,
  output logic          mem_r_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_d_lo,
  output logic [DW-1:0] mem_d_hi,
  output logic [BL-1:0] mem_be_lo_n,
  output logic [BL-1:0] mem_be_hi_n
);

  // internal events, named for the checks below
  logic wr_issue;
  logic rd_issue;
  logic cal_seen;

  qdr_sched_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_done (cal_done),
    .wq_empty (wq_empty),
    .rq_empty (rq_empty),
    .wq_pop_n (wq_pop_n),
    .rq_pop_n (rq_pop_n),
    .wr_issue (wr_issue),
    .rd_issue (rd_issue)
  );

  qdr_cmd_out #(.AW(AW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_issue (wr_issue),
    .rd_issue (rd_issue),
    .wr_addr  (wq_addr),
    .rd_addr  (rq_addr),
    .mem_w_n  (mem_w_n),
    .mem_r_n  (mem_r_n),
    .mem_addr (mem_addr)
  );

  qdr_wburst_seq #(.DW(DW), .BL(BL)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_issue),
    .w0      (wq_word0),
    .w1      (wq_word1),
    .w2      (wq_word2),
    .w3      (wq_word3),
    .b0_n    (wq_be0_n),
    .b1_n    (wq_be1_n),
    .b2_n    (wq_be2_n),
    .b3_n    (wq_be3_n),
    .d_lo    (mem_d_lo),
    .d_hi    (mem_d_hi),
    .be_lo_n (mem_be_lo_n),
    .be_hi_n (mem_be_hi_n)
  );

  // sticky record of calibration, used only by the checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cal_seen <= 1'b0;
    else if (cal_done) cal_seen <= 1'b1;
  end

  // R2: nothing leaves before calibration is seen
  assert_cal_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_seen |-> (mem_w_n && mem_r_n && wq_pop_n && rq_pop_n));

  // R4: write pop becomes a write command with the popped address
  assert_wcmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wq_pop_n |=> (!mem_w_n && mem_addr == $past(wq_addr)));

  // R5: read pop becomes a read command with the popped address
  assert_rcmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_pop_n |=> (!mem_r_n && mem_addr == $past(rq_addr)));

  // R11: address is held in command-free cycles
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_w_n && mem_r_n) |-> $stable(mem_addr));

  // R9, R10: second beat carries words 2 and 3 with their enables
  assert_beat_two_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n |=> (mem_d_lo == $past(wq_word2, 2) && mem_d_hi == $past(wq_word3, 2)
                  && mem_be_lo_n == $past(wq_be2_n, 2) && mem_be_hi_n == $past(wq_be3_n, 2)));

  // R9: quiet data outside a burst
  assert_data_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_w_n && $past(mem_w_n)) |-> (mem_d_lo == '0 && mem_d_hi == '0 && (&mem_be_lo_n)));

endmodule

// File: tb/tb_qdr_burst_sched.sv
`timescale 1ns/1ps
module tb_qdr_burst_sched;

  localparam int AW = 19;
  localparam int DW = 36;
  localparam int BL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_done = 1'b0;
  logic          wq_empty, rq_empty, wq_pop_n, rq_pop_n;
  logic [AW-1:0] wq_addr, rq_addr, mem_addr;
  logic [DW-1:0] wq_word0, wq_word1, wq_word2, wq_word3, mem_d_lo, mem_d_hi;
  logic [BL-1:0] wq_be0_n, wq_be1_n, wq_be2_n, wq_be3_n, mem_be_lo_n, mem_be_hi_n;
  logic          mem_w_n, mem_r_n;

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected data words and enables derived from the address
  function automatic logic [DW-1:0] wordf(input logic [AW-1:0] a, input int k);
    logic [DW-1:0] v;
    v = '0;
    v[AW+3:4] = a;
    v[3:0] = 4'(k);
    if (k[0]) v = ~v;
    return v;
  endfunction
  function automatic logic [BL-1:0] bef(input logic [AW-1:0] a, input int k);
    return BL'(a[3:0] + 4'(k * 5));
  endfunction

  // show-ahead queue models
  logic [AW-1:0] wmem [64];
  logic [AW-1:0] rmem [64];
  logic [5:0] whead = '0, wtail = '0, rhead = '0, rtail = '0;
  always @(posedge clk) begin
    if (!wq_pop_n) whead <= whead + 6'd1;
    if (!rq_pop_n) rhead <= rhead + 6'd1;
  end
  assign wq_empty = (whead == wtail);
  assign rq_empty = (rhead == rtail);
  assign wq_addr  = wmem[whead];
  assign rq_addr  = rmem[rhead];
  assign wq_word0 = wordf(wq_addr, 0);
  assign wq_word1 = wordf(wq_addr, 1);
  assign wq_word2 = wordf(wq_addr, 2);
  assign wq_word3 = wordf(wq_addr, 3);
  assign wq_be0_n = bef(wq_addr, 0);
  assign wq_be1_n = bef(wq_addr, 1);
  assign wq_be2_n = bef(wq_addr, 2);
  assign wq_be3_n = bef(wq_addr, 3);

  task automatic push_w(input logic [AW-1:0] a);
    wmem[wtail] = a;
    wtail = wtail + 6'd1;
  endtask
  task automatic push_r(input logic [AW-1:0] a);
    rmem[rtail] = a;
    rtail = rtail + 6'd1;
  endtask

  qdr_burst_sched #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done),
    .wq_empty(wq_empty), .wq_pop_n(wq_pop_n), .wq_addr(wq_addr),
    .wq_word0(wq_word0), .wq_word1(wq_word1), .wq_word2(wq_word2), .wq_word3(wq_word3),
    .wq_be0_n(wq_be0_n), .wq_be1_n(wq_be1_n), .wq_be2_n(wq_be2_n), .wq_be3_n(wq_be3_n),
    .rq_empty(rq_empty), .rq_pop_n(rq_pop_n), .rq_addr(rq_addr),
    .mem_w_n(mem_w_n), .mem_r_n(mem_r_n), .mem_addr(mem_addr),
    .mem_d_lo(mem_d_lo), .mem_d_hi(mem_d_hi),
    .mem_be_lo_n(mem_be_lo_n), .mem_be_hi_n(mem_be_hi_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // command log, sampled at the falling edge
  int            lg_n = 0;
  int            lg_kind [64];
  int            lg_cyc  [64];
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_d [64][4];
  logic [BL-1:0] lg_b [64][4];
  bit            pend2 = 0;
  bit            prev_w = 0, prev_r = 0;
  int            lastw = 0;

  always @(negedge clk) begin
    if (pend2) begin
      lg_d[lastw][2] = mem_d_lo; lg_d[lastw][3] = mem_d_hi;
      lg_b[lastw][2] = mem_be_lo_n; lg_b[lastw][3] = mem_be_hi_n;
      pend2 = 0;
    end
    if (rst_n && (!mem_w_n || !mem_r_n)) begin
      check("R8 controls exclusive", {62'd0, mem_w_n, mem_r_n},
            {62'd0, !mem_r_n, !mem_w_n} | 64'd0);
      check("R7 same-kind spacing", {62'd0, (!mem_w_n && prev_w), (!mem_r_n && prev_r)}, 64'd0);
      if (lg_n < 64) begin
        lg_kind[lg_n] = mem_w_n ? 1 : 0;
        lg_cyc[lg_n]  = cyc;
        lg_addr[lg_n] = mem_addr;
        if (!mem_w_n) begin
          lg_d[lg_n][0] = mem_d_lo; lg_d[lg_n][1] = mem_d_hi;
          lg_b[lg_n][0] = mem_be_lo_n; lg_b[lg_n][1] = mem_be_hi_n;
          lastw = lg_n;
          pend2 = 1;
        end
        lg_n++;
      end
    end
    prev_w = !mem_w_n;
    prev_r = !mem_r_n;
  end

  task automatic check_write_entry(input int i, input logic [AW-1:0] a);
    check("R4 write address", 64'(lg_addr[i]), 64'(a));
    for (int k = 0; k < 4; k++) begin
      check("R9 burst word", 64'(lg_d[i][k]), 64'(wordf(a, k)));
      check("R10 byte enables", 64'(lg_b[i][k]), 64'(bef(a, k)));
    end
  endtask

  // R1 and R2: reset values, then no traffic before calibration
  task automatic t_reset_and_gate();
    @(negedge clk);
    check("R1 w ctrl", 64'(mem_w_n), 64'd1);
    check("R1 r ctrl", 64'(mem_r_n), 64'd1);
    check("R1 addr", 64'(mem_addr), 64'd0);
    check("R1 data", 64'(mem_d_lo | mem_d_hi), 64'd0);
    check("R1 enables", 64'({mem_be_lo_n, mem_be_hi_n}), 64'({2*BL{1'b1}}));
    for (int i = 0; i < 3; i++) begin
      push_w(AW'(32'h100 + i));
      push_r(AW'(32'h200 + i));
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pops after reset", 64'({wq_pop_n, rq_pop_n}), 64'd3);
    repeat (10) @(negedge clk);
    check("R2 no pop before cal", 64'({wq_pop_n, rq_pop_n}), 64'd3);
    check("R2 no command before cal", 64'(lg_n), 64'd0);
  endtask

  // R2, R3, R5, R6, R9, R10: full-rate interleave released by calibration
  task automatic t_interleave();
    int c0, base;
    base = lg_n;
    c0 = cyc;
    cal_done = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 command count", 64'(lg_n - base), 64'd6);
    check("R2 first command cycle", 64'(lg_cyc[base] - c0), 64'd3);
    check("R3 write first", 64'(lg_kind[base]), 64'd0);
    for (int i = 0; i < 6; i++) begin
      check("R6 alternating kind", 64'(lg_kind[base+i]), 64'(i % 2));
      check("R6 consecutive cycles", 64'(lg_cyc[base+i] - c0), 64'(3 + i));
      if (i % 2 == 0) check_write_entry(base + i, AW'(32'h100 + i/2));
      else check("R5 read address", 64'(lg_addr[base+i]), 64'(32'h200 + i/2));
    end
  endtask

  // R7, R9, R11: write-only stream
  task automatic t_write_only();
    int c0, base;
    base = lg_n;
    c0 = cyc;
    for (int i = 0; i < 3; i++) push_w(AW'(32'h300 + i));
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R11 addr held in gap", 64'(mem_addr), 64'(32'h300));
    check("R7 write gap", 64'(mem_w_n), 64'd1);
    repeat (5) @(negedge clk);
    check("R9 idle data zero", 64'(mem_d_lo | mem_d_hi), 64'd0);
    check("R10 idle enables high", 64'({mem_be_lo_n, mem_be_hi_n}), 64'({2*BL{1'b1}}));
    check("R11 addr held after stream", 64'(mem_addr), 64'(32'h302));
    check("R7 write count", 64'(lg_n - base), 64'd3);
    for (int i = 0; i < 3; i++) begin
      check("R7 write every second cycle", 64'(lg_cyc[base+i] - c0), 64'(2 + 2*i));
      check_write_entry(base + i, AW'(32'h300 + i));
    end
  endtask

  // R5, R7: read-only stream
  task automatic t_read_only();
    int c0, base;
    base = lg_n;
    c0 = cyc;
    for (int i = 0; i < 3; i++) push_r(AW'(32'h400 + i));
    repeat (9) @(negedge clk);
    check("R7 read count", 64'(lg_n - base), 64'd3);
    for (int i = 0; i < 3; i++) begin
      check("R7 read every second cycle", 64'(lg_cyc[base+i] - c0), 64'(2 + 2*i));
      check("R5 read kind", 64'(lg_kind[base+i]), 64'd1);
      check("R5 read address", 64'(lg_addr[base+i]), 64'(32'h400 + i));
    end
  endtask

  // R12: quiet when both queues empty
  task automatic t_quiet();
    int base;
    base = lg_n;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!wq_pop_n || !rq_pop_n) check("R12 pop while empty", 64'd1, 64'd0);
    end
    check("R12 no command while empty", 64'(lg_n - base), 64'd0);
    check("R12 controls high", 64'({mem_w_n, mem_r_n}), 64'd3);
  endtask

  // R3: write and read arriving together from idle
  task automatic t_priority();
    int c0, base;
    base = lg_n;
    c0 = cyc;
    push_r(AW'(32'h500));
    push_w(AW'(32'h600));
    repeat (6) @(negedge clk);
    check("R3 two commands", 64'(lg_n - base), 64'd2);
    check("R3 write before read", 64'(lg_kind[base]), 64'd0);
    check("R3 write cycle", 64'(lg_cyc[base] - c0), 64'd2);
    check("R3 read next cycle", 64'(lg_cyc[base+1] - c0), 64'd3);
    check_write_entry(base, AW'(32'h600));
    check("R5 read address", 64'(lg_addr[base+1]), 64'(32'h500));
  endtask

  bit done = 0;

  initial begin
    t_reset_and_gate();
    t_interleave();
    t_write_only();
    t_read_only();
    t_quiet();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule